// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is a synthesizable behavioural model of the command side of a parallel NOR flash memory. A host drives chip enable, write enable and output enable strobes, an address and a data word. Each clock cycle with chip enable and write enable low is one bus write. Each clock cycle with chip enable and output enable low and write enable high is one bus read. Multi-write unlock sequences are decoded into word program, sector erase, a shortened program mode, and erase suspend and resume. A counter stands in for the time each program or erase takes, and a ready output stays low for that time.

The storage is a small register array split into equal sectors. A parameter mask marks some sectors as protected. Programming can only clear bits. Erase sets a whole sector to ones. While an operation is in progress, a read returns a status word in place of array data. Bit 7 of that word shows the complement of the bit being written, and bit 6 flips on every read. The synchronous reset input aborts any operation and returns the interface to plain reads, but the stored contents are kept. Only the low `ARR_AW` address bits select a word, so the array repeats across the address space. The full address is still compared for the unlock cycles.

Top module: `nfc_flash_cmd`

## Requirements
- R1: After reset, ready is 1. In any cycle that is not a read cycle (ce_n=0, oe_n=0, we_n=1), dout is 0.
- R2: A program command is four writes: 0xAA to address 0x555, then 0x55 to address 0x2AA, then 0xA0 to any address, then the data to the target address. Command bytes are compared on din[7:0]. When ready returns to 1, reading the target address returns the stored word.
- R3: Programming can only clear bits. The stored word becomes the old word ANDed with the written data.
- R4: A write that does not match the expected step of a sequence returns the interface to read mode. This includes writing 0xF0 as the command byte. A later data write then programs nothing.
- R5: The unlock writes followed by 0x20 enter a bypass mode. In that mode, 0xA0 followed by one data write programs a word. Writing 0x90 and then 0x00 leaves the mode, and after that a two-write program has no effect.
- R6: A sector erase is six writes: 0xAA@0x555, 0x55@0x2AA, 0x80, 0xAA@0x555, 0x55@0x2AA, then 0x30 to any address inside the sector. The sector number is address bits [ARR_AW-1:ARR_AW-SEC_W]. Afterwards every word of that sector reads 0xFFFF, and other sectors are unchanged.
- R7: Ready goes low only in the cycle after a bus write. It then stays low for exactly PROG_CYCLES cycles for a program, and for exactly ERASE_CYCLES cycles for an erase that is not suspended.
- R8: A read while ready is 0 returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Every bit other than 6 and 7 is 0.
- R9: Status bit 6 changes value on each read cycle made while ready is 0. After completion, reads return array data.
- R10: Writing 0xB0 during an erase suspends it, and ready is 1 in the next cycle. While suspended, sectors other than the one being erased can be read and programmed. A program aimed at the erasing sector is ignored. Writing 0x30 resumes the erase, which then completes.
- R11: Program and erase commands aimed at a sector whose PROTECT bit is 1 are ignored: ready stays 1 and the contents are unchanged.
- R12: Driving rst_n low aborts an operation in progress and leaves bypass mode. The target word keeps its old value, and ready is 1 after the reset cycle.
- R13: Writes made while a program is in progress are ignored and do not advance a command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data and command byte |
| dout | output | DATA_W | Array data or status word during read cycles, else 0 |
| ready | output | 1 | 1 when idle or suspended, 0 while programming or erasing |

## Verification
The program function is exercised with several write patterns:
- a complete four-write sequence;
- sequences broken at the second step or by the 0xF0 byte;
- writes landing while a program is in progress;
- the two-write bypass form, both before and after leaving the mode.

Each pattern separates "sequence accepted" from "sequence dropped" through the stored word and the ready line. Programming a word that already holds data shows whether bits are ANDed or overwritten. Erases are applied to single sectors, to a protected sector, and to a sector that is suspended, programmed around and then resumed. These cases show whether erase stays inside its sector and whether the erase counter survives a suspend. A reset in the middle of an operation checks that the stored word is preserved and that bypass mode is cleared.

// File: rtl/nfc_pkg.sv
// Shared types and command bytes for the NOR flash command interface.
package nfc_pkg;
    localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
    localparam logic [7:0] CMD_BYP_X1  = 8'h90;
    localparam logic [7:0] CMD_BYP_X2  = 8'h00;

    typedef enum logic [3:0] {
        S_RD, S_U1, S_U2, S_PROG, S_ESET, S_EU1, S_EU2, S_BYP, S_BPROG, S_BEXIT
    } seq_state_t;

    typedef enum logic [2:0] {
        E_IDLE, E_PROG, E_ERASE, E_SUSP, E_SUSP_PROG
    } eng_state_t;
endpackage

// File: rtl/nfc_seq.sv
// Command sequence decoder. It walks the unlock steps on each accepted bus
// write and emits one-cycle start pulses for program and erase.
// Assumes: wr is a one-cycle strobe; accept is low while an operation runs.
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd,
    output logic              start_prog,
    output logic              start_erase,
    output logic              cmd_idle
);
    localparam logic [ADDR_W-1:0] ADR_U1 = ADDR_W'(11'h555);
    localparam logic [ADDR_W-1:0] ADR_U2 = ADDR_W'(11'h2AA);

    seq_state_t st;
    logic       take;
    logic       is_u1, is_u2;

    assign take  = wr && accept;
    assign is_u1 = (addr == ADR_U1) && (cmd == CMD_UNLOCK1);
    assign is_u2 = (addr == ADR_U2) && (cmd == CMD_UNLOCK2);

    assign start_prog  = take && (st == S_PROG || st == S_BPROG);
    assign start_erase = take && (st == S_EU2) && (cmd == CMD_SECTOR);
    assign cmd_idle    = (st == S_RD) || (st == S_BYP);

    // Advance the sequence on each accepted write; any mismatch falls back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_RD;
        end else if (take) begin
            unique case (st)
                S_RD:    st <= is_u1 ? S_U1 : S_RD;
                S_U1:    st <= is_u2 ? S_U2 : S_RD;
                S_U2:    st <= (cmd == CMD_PROGRAM) ? S_PROG :
                               (cmd == CMD_ERASE)   ? S_ESET :
                               (cmd == CMD_BYPASS)  ? S_BYP  : S_RD;
                S_PROG:  st <= S_RD;
                S_ESET:  st <= is_u1 ? S_EU1 : S_RD;
                S_EU1:   st <= is_u2 ? S_EU2 : S_RD;
                S_EU2:   st <= S_RD;
                S_BYP:   st <= (cmd == CMD_PROGRAM) ? S_BPROG :
                               (cmd == CMD_BYP_X1)  ? S_BEXIT : S_BYP;
                S_BPROG: st <= S_BYP;
                S_BEXIT: st <= (cmd == CMD_BYP_X2) ? S_RD : S_BYP;
                default: st <= S_RD;
            endcase
        end
    end
endmodule

// File: rtl/nfc_engine.sv
// Operation engine. It latches the target of a program or erase, times it
// with down-counters, handles erase suspend and resume, and pulses the
// commit strobes to the array. Assumes start pulses come from nfc_seq.
module nfc_engine
    import nfc_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ARR_AW       = 6,
    parameter int SEC_W        = 2,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32,
    parameter logic [(1<<SEC_W)-1:0] PROTECT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ARR_AW-1:0] word,
    input  logic              cmd_idle,
    input  logic              start_prog,
    input  logic              start_erase,
    output logic              accept,
    output logic              busy,
    output logic              st_bit7,
    output logic              prog_commit,
    output logic [ARR_AW-1:0] prog_word,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_commit,
    output logic [SEC_W-1:0]  erase_sec
);
    localparam int PCW = $clog2(PROG_CYCLES + 1);
    localparam int ECW = $clog2(ERASE_CYCLES + 1);

    eng_state_t     st;
    logic [PCW-1:0] pcnt;
    logic [ECW-1:0] ecnt;
    logic [SEC_W-1:0] sec;
    logic           prot_ok, suspend_wr, resume_wr;

    assign sec        = word[ARR_AW-1 -: SEC_W];
    assign prot_ok    = !PROTECT[sec];
    assign suspend_wr = wr && (wdata[7:0] == CMD_SUSPEND);
    assign resume_wr  = wr && cmd_idle && (wdata[7:0] == CMD_RESUME);

    assign accept       = (st == E_IDLE) || (st == E_SUSP);
    assign busy         = (st == E_PROG) || (st == E_ERASE) || (st == E_SUSP_PROG);
    assign st_bit7      = (st == E_ERASE) ? 1'b0 : ~prog_data[7];
    assign prog_commit  = (st == E_PROG || st == E_SUSP_PROG) && (pcnt == '0);
    assign erase_commit = (st == E_ERASE) && (ecnt == '0) && !suspend_wr;

    // Operation state, counters and latched targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= E_IDLE;
            pcnt      <= '0;
            ecnt      <= '0;
            prog_word <= '0;
            prog_data <= '0;
            erase_sec <= '0;
        end else begin
            unique case (st)
                E_IDLE: begin
                    if (start_prog && prot_ok) begin
                        prog_word <= word;
                        prog_data <= wdata;
                        pcnt      <= PCW'(PROG_CYCLES - 1);
                        st        <= E_PROG;
                    end else if (start_erase && prot_ok) begin
                        erase_sec <= sec;
                        ecnt      <= ECW'(ERASE_CYCLES - 1);
                        st        <= E_ERASE;
                    end
                end
                E_PROG: begin
                    if (pcnt == '0) st <= E_IDLE;
                    else            pcnt <= pcnt - 1'b1;
                end
                E_ERASE: begin
                    if (suspend_wr)        st <= E_SUSP;
                    else if (ecnt == '0)   st <= E_IDLE;
                    else                   ecnt <= ecnt - 1'b1;
                end
                E_SUSP: begin
                    if (start_prog && prot_ok && sec != erase_sec) begin
                        prog_word <= word;
                        prog_data <= wdata;
                        pcnt      <= PCW'(PROG_CYCLES - 1);
                        st        <= E_SUSP_PROG;
                    end else if (resume_wr) begin
                        st <= E_ERASE;
                    end
                end
                E_SUSP_PROG: begin
                    if (pcnt == '0) st <= E_SUSP;
                    else            pcnt <= pcnt - 1'b1;
                end
                default: st <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nfc_array.sv
// Register-based storage. A program commit ANDs new data into one word; an
// erase commit sets every word of one sector to ones. Contents have no reset
// so that they survive the interface reset, as nonvolatile cells would.
module nfc_array #(
    parameter int DATA_W = 16,
    parameter int ARR_AW = 6,
    parameter int SEC_W  = 2
) (
    input  logic              clk,
    input  logic              prog_en,
    input  logic [ARR_AW-1:0] prog_word,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [SEC_W-1:0]  erase_sec,
    input  logic [ARR_AW-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS     = 1 << ARR_AW;
    localparam int SEC_WORDS = WORDS >> SEC_W;

    logic [DATA_W-1:0] mem [WORDS];

    assign rd_data = mem[rd_word];

    // Apply commit strobes; erase and program never coincide.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (erase_en && erase_sec == SEC_W'(i / SEC_WORDS))
                mem[i] <= '1;
            else if (prog_en && prog_word == ARR_AW'(i))
                mem[i] <= mem[i] & prog_data;
        end
    end
endmodule

// File: rtl/nfc_flash_cmd.sv
// Top of the NOR flash command interface. It turns bus strobes into
// write and read events, wires the sequence decoder, engine and array,
// and muxes array data or the busy status word onto dout.
// Assumes: ADDR_W >= 11 and DATA_W >= 8; one strobe cycle is one access.
module nfc_flash_cmd
    import nfc_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 16,
    parameter int ARR_AW       = 6,
    parameter int SEC_W        = 2,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32,
    parameter logic [(1<<SEC_W)-1:0] PROTECT = 4'b1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ready
);
    logic wr, rd;
    logic start_prog, start_erase, cmd_idle, accept, busy, st_bit7;
    logic prog_commit, erase_commit, tog;
    logic [ARR_AW-1:0] prog_word;
    logic [DATA_W-1:0] prog_data, rd_data, status;
    logic [SEC_W-1:0]  erase_sec;

    assign wr = !ce_n && !we_n;
    assign rd = !ce_n && !oe_n && we_n;

    nfc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr(wr), .accept(accept), .addr(addr),
        .cmd(din[7:0]), .start_prog(start_prog), .start_erase(start_erase),
        .cmd_idle(cmd_idle)
    );

    nfc_engine #(
        .DATA_W(DATA_W), .ARR_AW(ARR_AW), .SEC_W(SEC_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .PROTECT(PROTECT)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(din), .word(addr[ARR_AW-1:0]),
        .cmd_idle(cmd_idle), .start_prog(start_prog), .start_erase(start_erase),
        .accept(accept), .busy(busy), .st_bit7(st_bit7),
        .prog_commit(prog_commit), .prog_word(prog_word), .prog_data(prog_data),
        .erase_commit(erase_commit), .erase_sec(erase_sec)
    );

    nfc_array #(.DATA_W(DATA_W), .ARR_AW(ARR_AW), .SEC_W(SEC_W)) u_arr (
        .clk(clk), .prog_en(prog_commit), .prog_word(prog_word),
        .prog_data(prog_data), .erase_en(erase_commit), .erase_sec(erase_sec),
        .rd_word(addr[ARR_AW-1:0]), .rd_data(rd_data)
    );

    // Toggle bit: flips on every read cycle made while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)          tog <= 1'b0;
        else if (rd && busy) tog <= ~tog;
    end

    // Status word: bit 7 data-complement poll, bit 6 toggle, rest zero.
    always_comb begin
        status    = '0;
        status[7] = st_bit7;
        status[6] = tog;
    end

    assign dout  = !rd ? '0 : (busy ? status : rd_data);
    assign ready = !busy;
endmodule

// File: rtl/nfc_flash_cmd_chk.sv
// Port-level checker for nfc_flash_cmd, attached with bind below.
module nfc_flash_cmd_chk #(
    parameter int DATA_W   = 16,
    parameter int MAX_BUSY = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              ready
);
    localparam int RW = $clog2(MAX_BUSY + 2) + 1;

    logic          rd, wr;
    logic [RW-1:0] run;

    assign rd = !ce_n && !oe_n && we_n;
    assign wr = !ce_n && !we_n;

    // Length of the current stretch of ready low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (ready)      run <= '0;
        else if (run != '1)  run <= run + 1'b1;
    end

    assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> dout == '0);

    assert_idle_after_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ready);

    assert_busy_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr));

    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(MAX_BUSY));

    assert_status_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ready) |-> (dout[5:0] == '0 && (dout >> 8) == '0));

    assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ready) ##1 (rd && !ready) |-> dout[6] != $past(dout[6]));
endmodule

bind nfc_flash_cmd nfc_flash_cmd_chk #(
    .DATA_W(DATA_W),
    .MAX_BUSY((ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .dout(dout), .ready(ready)
);

// File: tb/nfc_flash_cmd_bench.sv
// Directed bench for nfc_flash_cmd: one task per scenario.
module nfc_flash_cmd_bench;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 16;
    localparam int PROG_CYCLES  = 8;
    localparam int ERASE_CYCLES = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic ready;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nfc_flash_cmd #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_nfc_flash_cmd (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .ready(ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #5 d = dout;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic unlock();
        bus_wr(11'h555, 16'h00AA);
        bus_wr(11'h2AA, 16'h0055);
    endtask

    task automatic prog_full(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        unlock();
        bus_wr(11'h555, 16'h00A0);
        bus_wr(a, d);
    endtask

    task automatic erase_start(input logic [ADDR_W-1:0] a);
        unlock();
        bus_wr(11'h555, 16'h0080);
        unlock();
        bus_wr(a, 16'h0030);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", ready, 1);
        chk("R1 dout idle", dout, 0);
    endtask

    task automatic t_init_erase();
        int n;
        logic [DATA_W-1:0] v;
        erase_start(11'h000);
        wait_ready(n);
        chk("R7 erase busy cycles", n, ERASE_CYCLES);
        erase_start(11'h010); wait_ready(n);
        erase_start(11'h020); wait_ready(n);
        bus_rd(11'h00F, v);
        chk("R6 erased word", v, 16'hFFFF);
    endtask

    task automatic t_program();
        int n;
        logic [DATA_W-1:0] v;
        prog_full(11'h005, 16'h12F0);
        chk("R7 ready low after program", ready, 0);
        wait_ready(n);
        chk("R7 program busy cycles", n, PROG_CYCLES);
        bus_rd(11'h005, v);
        chk("R2 programmed word", v, 16'h12F0);
        prog_full(11'h005, 16'hFF0F); wait_ready(n);
        bus_rd(11'h005, v);
        chk("R3 AND of old and new", v, 16'h1200);
    endtask

    task automatic t_status();
        int n;
        logic [DATA_W-1:0] v1, v2;
        prog_full(11'h006, 16'h0080);
        bus_rd(11'h006, v1);
        bus_rd(11'h006, v2);
        chk("R8 bit7 complement", v1[7], 0);
        chk("R8 other bits zero", {v1[15:8], v1[5:0]}, 0);
        chk("R9 bit6 toggles", v1[6] ^ v2[6], 1);
        wait_ready(n);
        bus_rd(11'h006, v1);
        chk("R9 data after completion", v1, 16'h0080);
        prog_full(11'h007, 16'h0001);
        bus_rd(11'h007, v1);
        chk("R8 bit7 complement of zero", v1[7], 1);
        wait_ready(n);
        erase_start(11'h010);
        bus_rd(11'h010, v1);
        chk("R8 bit7 zero during erase", v1[7], 0);
        wait_ready(n);
    endtask

    task automatic t_mismatch();
        logic [DATA_W-1:0] v;
        bus_wr(11'h555, 16'h00AA);
        bus_wr(11'h123, 16'h0055);
        bus_wr(11'h555, 16'h00A0);
        bus_wr(11'h008, 16'h0000);
        chk("R4 no busy after broken sequence", ready, 1);
        bus_rd(11'h008, v);
        chk("R4 word untouched", v, 16'hFFFF);
        unlock();
        bus_wr(11'h555, 16'h00F0);
        bus_wr(11'h009, 16'h0000);
        bus_rd(11'h009, v);
        chk("R4 reset command drops sequence", v, 16'hFFFF);
    endtask

    task automatic t_busy_writes();
        int n;
        logic [DATA_W-1:0] v;
        prog_full(11'h00A, 16'h00F0);
        bus_wr(11'h555, 16'h00AA);
        wait_ready(n);
        bus_wr(11'h2AA, 16'h0055);
        bus_wr(11'h555, 16'h00A0);
        bus_wr(11'h00B, 16'h0000);
        chk("R13 ready after late writes", ready, 1);
        bus_rd(11'h00B, v);
        chk("R13 busy write ignored", v, 16'hFFFF);
    endtask

    task automatic t_bypass();
        int n;
        logic [DATA_W-1:0] v;
        unlock();
        bus_wr(11'h555, 16'h0020);
        bus_wr(11'h000, 16'h00A0);
        bus_wr(11'h020, 16'h3333);
        chk("R5 bypass program busy", ready, 0);
        wait_ready(n);
        bus_rd(11'h020, v);
        chk("R5 bypass programmed", v, 16'h3333);
        bus_wr(11'h000, 16'h0090);
        bus_wr(11'h000, 16'h0000);
        bus_wr(11'h000, 16'h00A0);
        bus_wr(11'h021, 16'h0000);
        bus_rd(11'h021, v);
        chk("R5 bypass exited", v, 16'hFFFF);
    endtask

    task automatic t_protect();
        logic [DATA_W-1:0] v0, v;
        bus_rd(11'h030, v0);
        prog_full(11'h030, 16'h0000);
        chk("R11 program protected ready", ready, 1);
        erase_start(11'h031);
        chk("R11 erase protected ready", ready, 1);
        bus_rd(11'h030, v);
        chk("R11 protected contents", v, v0);
    endtask

    task automatic t_suspend();
        int n;
        logic [DATA_W-1:0] v;
        prog_full(11'h012, 16'h0F0F); wait_ready(n);
        erase_start(11'h010);
        repeat (3) @(negedge clk);
        bus_wr(11'h000, 16'h00B0);
        chk("R10 ready when suspended", ready, 1);
        bus_rd(11'h005, v);
        chk("R10 read other sector", v, 16'h1200);
        prog_full(11'h013, 16'h0000);
        chk("R10 program in erasing sector ignored", ready, 1);
        prog_full(11'h022, 16'h0055);
        wait_ready(n);
        chk("R10 suspended program cycles", n, PROG_CYCLES);
        bus_rd(11'h022, v);
        chk("R10 suspended program data", v, 16'h0055);
        bus_wr(11'h000, 16'h0030);
        chk("R10 resume busy", ready, 0);
        wait_ready(n);
        bus_rd(11'h012, v);
        chk("R10 erase finished after resume", v, 16'hFFFF);
        bus_rd(11'h022, v);
        chk("R10 other sector kept", v, 16'h0055);
    endtask

    task automatic t_erase_iso();
        int n;
        logic [DATA_W-1:0] v;
        erase_start(11'h003); wait_ready(n);
        bus_rd(11'h005, v);
        chk("R6 sector erased", v, 16'hFFFF);
        bus_rd(11'h020, v);
        chk("R6 neighbour untouched", v, 16'h3333);
    endtask

    task automatic t_abort();
        logic [DATA_W-1:0] v;
        unlock();
        bus_wr(11'h555, 16'h0020);
        bus_wr(11'h000, 16'h00A0);
        bus_wr(11'h001, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12 ready after abort", ready, 1);
        bus_rd(11'h001, v);
        chk("R12 aborted word kept", v, 16'hFFFF);
        bus_wr(11'h000, 16'h00A0);
        bus_wr(11'h002, 16'h0000);
        bus_rd(11'h002, v);
        chk("R12 bypass cleared", v, 16'hFFFF);
    endtask

    initial begin
        t_reset();
        t_init_erase();
        t_program();
        t_status();
        t_mismatch();
        t_busy_writes();
        t_bypass();
        t_protect();
        t_suspend();
        t_erase_iso();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule